// File: doc/BRIEF.md
# Flash Page-Load Command Sequencer

This block sits on the host side of a NAND flash device that has an on-chip buffer RAM and a memory-mapped register file. A single start pulse makes it carry out one complete page load from the flash array into a chosen buffer. It latches the flash block, page and sector addresses, the buffer sector window and the die and buffer selects. It then writes the set-up registers and the load command in a fixed order. It polls the interrupt register until the device reports completion, reads the controller status, clears the interrupt if required and reports the outcome.

Every register access is a single transaction on a simple synchronous bus. A write or read strobe is held, with address and data steady, until the device acknowledges. The sequencer keeps `busy` high for the whole sequence. It ends with a one-cycle `done` pulse. Sticky outcome flags for a device error, a poll timeout or rejected arguments remain valid until the next accepted start.

Top module: `page_load_seq`

## Requirements
- R1: The first transaction is a write to F100h. Bit 15 carries `die_sel`, bits BLK_W-1:0 carry `blk_addr`, and all other bits are 0.
- R2: The second transaction is a write to F107h. Bits PAGE_W+1:2 carry `page_addr`, bits 1:0 carry `sect_addr`, and all other bits are 0.
- R3: The third transaction is a write to F200h. Bits 9:8 carry `buf_sect`, bits 1:0 carry `buf_count` minus one, and all other bits are 0.
- R4: The fourth transaction is a write to F101h. Bit 15 carries `buf_sel`, and all other bits are 0.
- R5: The fifth transaction writes the load command to F220h. The data is 0013h when `cmd_alt` is 1 and 0000h when it is 0.
- R6: After the command, the sequencer reads F241h repeatedly. It stops polling only on a read with bit 15 = 1 that follows an earlier read in this sequence with bit 15 = 0. The other bits of the read word are ignored.
- R7: After completion the sequencer reads F240h once. Bit 10 of that word sets the sticky `err` flag, and the other bits are ignored.
- R8: When `auto_clear` is 0, the last transaction writes 0000h to F241h. When `auto_clear` is 1, no transaction follows the status read.
- R9: A start is rejected when `buf_count` is 0, when `buf_count` is above 4, or when `buf_sect` + `buf_count` is above 4. A rejected start issues no bus transaction and gives `done` together with `arg_err` one cycle after the start.
- R10: `busy` rises in the cycle after an accepted start and falls in the cycle that `done` is high. A start while `busy` is high has no effect. No strobe is active while `busy` is low.
- R11: A strobe, with its address and write data, stays unchanged until `bus_ack` is sampled high. `bus_wr` and `bus_rd` are never high together.
- R12: When `poll_limit` is nonzero, the sequence is aborted after `poll_limit` poll reads without completion. The abort sets `tmo`, gives `done`, and issues no further transactions. A completion on the last allowed read takes precedence over the timeout. When `poll_limit` is 0, there is no timeout.
- R13: `done` is high for exactly one cycle. An accepted start clears `err`, `tmo` and `arg_err`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Start pulse for one page load |
| blk_addr | input | BLK_W | Flash block address |
| page_addr | input | PAGE_W | Page within the block |
| sect_addr | input | 2 | Sector within the page |
| buf_sect | input | 2 | First buffer sector (0 to 3) |
| buf_count | input | 3 | Number of buffer sectors (1 to 4) |
| die_sel | input | 1 | Flash die select |
| buf_sel | input | 1 | Buffer/die select for dual-die parts |
| cmd_alt | input | 1 | Selects command word 0013h instead of 0000h |
| auto_clear | input | 1 | Device clears its interrupt itself; skip the clear write |
| poll_limit | input | CNT_W | Maximum number of poll reads; 0 disables the timeout |
| bus_addr | output | 16 | Register address |
| bus_wdata | output | 16 | Write data |
| bus_wr | output | 1 | Write strobe |
| bus_rd | output | 1 | Read strobe |
| bus_rdata | input | 16 | Read data, valid with `bus_ack` |
| bus_ack | input | 1 | Transaction acknowledge |
| busy | output | 1 | Sequence in progress |
| done | output | 1 | One-cycle end-of-sequence pulse |
| err | output | 1 | Sticky: device reported a load error |
| tmo | output | 1 | Sticky: poll timeout |
| arg_err | output | 1 | Sticky: start rejected for an invalid sector window |

## Verification
The load is run with two contrasting argument sets, so that each field landing in its own bit range of each set-up word is distinguishable. These runs also cover both command words, both clear modes, zero and nonzero acknowledge delays, and both values of the status bit. The poll responses deliberately set every other bit, which separates a correct single-bit test from a whole-word test. A response that is already high before the first low read shows whether the sequencer waits for a real rising transition. Poll limits of exactly the completing read, one fewer than needed, and zero separate the completion, timeout and no-timeout outcomes. Out-of-window sector arguments and a start issued mid-sequence show whether the checks run before any bus traffic and whether a busy sequence ignores new starts.

// File: rtl/pls_pkg.sv
package pls_pkg;

    localparam logic [15:0] REG_BLK  = 16'hF100;
    localparam logic [15:0] REG_SEL  = 16'hF101;
    localparam logic [15:0] REG_PAGE = 16'hF107;
    localparam logic [15:0] REG_BUF  = 16'hF200;
    localparam logic [15:0] REG_CMD  = 16'hF220;
    localparam logic [15:0] REG_STAT = 16'hF240;
    localparam logic [15:0] REG_INT  = 16'hF241;

    localparam logic [15:0] CMD_PLAIN = 16'h0000;
    localparam logic [15:0] CMD_ALT   = 16'h0013;

    localparam int INT_BIT     = 15;
    localparam int ERR_BIT     = 10;
    localparam int BUF_SECTORS = 4;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_BLK,
        ST_PAGE,
        ST_BUF,
        ST_SEL,
        ST_CMD,
        ST_POLL,
        ST_STAT,
        ST_CLR
    } step_t;

endpackage

// File: rtl/pls_word_build.sv
module pls_word_build
    import pls_pkg::*;
#(
    parameter int BLK_W  = 10,
    parameter int PAGE_W = 6
) (
    input  step_t              step,
    input  logic               die,
    input  logic [BLK_W-1:0]   blk,
    input  logic [PAGE_W-1:0]  page,
    input  logic [1:0]         sect,
    input  logic [1:0]         bsa,
    input  logic [1:0]         cnt_m1,
    input  logic               dbs,
    input  logic               cmd_alt,
    output logic [15:0]        addr,
    output logic [15:0]        wdata,
    output logic               is_wr
);

    localparam int PAGE_LSB = 2;
    localparam int PAGE_MSB = PAGE_LSB + PAGE_W - 1;
    localparam int BSA_LSB  = 8;

    always_comb begin
        addr  = REG_INT;
        wdata = '0;
        is_wr = 1'b1;
        case (step)
            ST_BLK: begin
                addr             = REG_BLK;
                wdata[BLK_W-1:0] = blk;
                wdata[15]        = die;
            end
            ST_PAGE: begin
                addr                      = REG_PAGE;
                wdata[PAGE_MSB:PAGE_LSB]  = page;
                wdata[1:0]                = sect;
            end
            ST_BUF: begin
                addr                     = REG_BUF;
                wdata[BSA_LSB+1:BSA_LSB] = bsa;
                wdata[1:0]               = cnt_m1;
            end
            ST_SEL: begin
                addr      = REG_SEL;
                wdata[15] = dbs;
            end
            ST_CMD: begin
                addr  = REG_CMD;
                wdata = cmd_alt ? CMD_ALT : CMD_PLAIN;
            end
            ST_POLL: begin
                addr  = REG_INT;
                is_wr = 1'b0;
            end
            ST_STAT: begin
                addr  = REG_STAT;
                is_wr = 1'b0;
            end
            ST_CLR: begin
                addr  = REG_INT;
                wdata = '0;
            end
            default: begin
                addr  = REG_INT;
                is_wr = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/pls_bus_port.sv
module pls_bus_port #(
    parameter int ADDR_W = 16,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              req_wr,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic              fin,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [DATA_W-1:0] bus_rdata,
    input  logic              bus_ack
);

    typedef struct packed {
        logic              act;
        logic              wr;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] rdata;
        logic              fin;
    } port_s;

    localparam port_s PORT_RST = '0;

    port_s p_q, p_d;

    always_comb begin
        p_d     = p_q;
        p_d.fin = 1'b0;
        if (!p_q.act) begin
            if (req) begin
                p_d.act   = 1'b1;
                p_d.wr    = req_wr;
                p_d.addr  = req_addr;
                p_d.wdata = req_wdata;
            end
        end else if (bus_ack) begin
            p_d.act   = 1'b0;
            p_d.fin   = 1'b1;
            p_d.rdata = bus_rdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) p_q <= PORT_RST;
        else        p_q <= p_d;
    end

    assign fin       = p_q.fin;
    assign rd_data   = p_q.rdata;
    assign bus_addr  = p_q.addr;
    assign bus_wdata = p_q.wdata;
    assign bus_wr    = p_q.act &  p_q.wr;
    assign bus_rd    = p_q.act & ~p_q.wr;

endmodule

// File: rtl/pls_poll_timer.sv
module pls_poll_timer #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             tick,
    input  logic [CNT_W-1:0] limit,
    output logic             last_allowed
);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } tmr_s;

    localparam tmr_s TMR_RST = '0;

    tmr_s t_q, t_d;

    always_comb begin
        t_d = t_q;
        if (clr)
            t_d.cnt = '0;
        else if (tick && (t_q.cnt != '1))
            t_d.cnt = t_q.cnt + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) t_q <= TMR_RST;
        else        t_q <= t_d;
    end

    // true when the read in flight is the limit-th one
    assign last_allowed = (limit != '0) && (t_q.cnt >= limit - 1'b1);

endmodule

// File: rtl/page_load_seq.sv
module page_load_seq
    import pls_pkg::*;
#(
    parameter int BLK_W  = 10,
    parameter int PAGE_W = 6,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [BLK_W-1:0]  blk_addr,
    input  logic [PAGE_W-1:0] page_addr,
    input  logic [1:0]        sect_addr,
    input  logic [1:0]        buf_sect,
    input  logic [2:0]        buf_count,
    input  logic              die_sel,
    input  logic              buf_sel,
    input  logic              cmd_alt,
    input  logic              auto_clear,
    input  logic [CNT_W-1:0]  poll_limit,
    output logic [15:0]       bus_addr,
    output logic [15:0]       bus_wdata,
    output logic              bus_wr,
    output logic              bus_rd,
    input  logic [15:0]       bus_rdata,
    input  logic              bus_ack,
    output logic              busy,
    output logic              done,
    output logic              err,
    output logic              tmo,
    output logic              arg_err
);

    localparam int WIN_W = 4;

    typedef struct packed {
        step_t             step;
        logic              pend;
        logic              busy;
        logic              done;
        logic              err;
        logic              tmo;
        logic              arg_err;
        logic              seen_low;
        logic              die;
        logic [BLK_W-1:0]  blk;
        logic [PAGE_W-1:0] page;
        logic [1:0]        sect;
        logic [1:0]        bsa;
        logic [1:0]        cnt_m1;
        logic              dbs;
        logic              cmd_alt;
        logic              auto_clr;
    } seq_s;

    localparam seq_s SEQ_RST = '0;

    seq_s s_q, s_d;

    logic              req, fin, tmr_clr, tmr_tick, last_allowed;
    logic [15:0]       rd_data, w_addr, w_data;
    logic              w_is_wr;
    logic [CNT_W-1:0]  limit_q;
    logic [WIN_W-1:0]  win_end;
    logic              args_bad;
    logic              int_hi, stat_err;
    logic              unused_rd;

    assign win_end  = WIN_W'(buf_sect) + WIN_W'(buf_count);
    assign args_bad = (buf_count == 3'd0) || (buf_count > 3'(BUF_SECTORS))
                    || (win_end > WIN_W'(BUF_SECTORS));
    assign int_hi   = rd_data[INT_BIT];
    assign stat_err = rd_data[ERR_BIT];
    assign unused_rd = ^rd_data;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        req      = 1'b0;
        tmr_clr  = 1'b0;
        tmr_tick = 1'b0;
        if (s_q.step == ST_IDLE) begin
            if (start) begin
                s_d.err      = 1'b0;
                s_d.tmo      = 1'b0;
                s_d.arg_err  = 1'b0;
                s_d.seen_low = 1'b0;
                s_d.pend     = 1'b0;
                s_d.die      = die_sel;
                s_d.blk      = blk_addr;
                s_d.page     = page_addr;
                s_d.sect     = sect_addr;
                s_d.bsa      = buf_sect;
                s_d.cnt_m1   = 2'(buf_count - 3'd1);
                s_d.dbs      = buf_sel;
                s_d.cmd_alt  = cmd_alt;
                s_d.auto_clr = auto_clear;
                tmr_clr      = 1'b1;
                if (args_bad) begin
                    s_d.arg_err = 1'b1;
                    s_d.done    = 1'b1;
                end else begin
                    s_d.busy = 1'b1;
                    s_d.step = ST_BLK;
                end
            end
        end else if (!s_q.pend) begin
            req      = 1'b1;
            s_d.pend = 1'b1;
        end else if (fin) begin
            s_d.pend = 1'b0;
            case (s_q.step)
                ST_BLK:  s_d.step = ST_PAGE;
                ST_PAGE: s_d.step = ST_BUF;
                ST_BUF:  s_d.step = ST_SEL;
                ST_SEL:  s_d.step = ST_CMD;
                ST_CMD:  s_d.step = ST_POLL;
                ST_POLL: begin
                    if (int_hi && s_q.seen_low) begin
                        s_d.step = ST_STAT;
                    end else begin
                        tmr_tick = 1'b1;
                        if (!int_hi) s_d.seen_low = 1'b1;
                        if (last_allowed) begin
                            s_d.tmo  = 1'b1;
                            s_d.step = ST_IDLE;
                            s_d.busy = 1'b0;
                            s_d.done = 1'b1;
                        end
                    end
                end
                ST_STAT: begin
                    s_d.err = stat_err;
                    if (s_q.auto_clr) begin
                        s_d.step = ST_IDLE;
                        s_d.busy = 1'b0;
                        s_d.done = 1'b1;
                    end else begin
                        s_d.step = ST_CLR;
                    end
                end
                default: begin
                    s_d.step = ST_IDLE;
                    s_d.busy = 1'b0;
                    s_d.done = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q     <= SEQ_RST;
            limit_q <= '0;
        end else begin
            s_q <= s_d;
            if (s_q.step == ST_IDLE && start) limit_q <= poll_limit;
        end
    end

    pls_word_build #(.BLK_W(BLK_W), .PAGE_W(PAGE_W)) u_words (
        .step    (s_q.step),
        .die     (s_q.die),
        .blk     (s_q.blk),
        .page    (s_q.page),
        .sect    (s_q.sect),
        .bsa     (s_q.bsa),
        .cnt_m1  (s_q.cnt_m1),
        .dbs     (s_q.dbs),
        .cmd_alt (s_q.cmd_alt),
        .addr    (w_addr),
        .wdata   (w_data),
        .is_wr   (w_is_wr)
    );

    pls_bus_port #(.ADDR_W(16), .DATA_W(16)) u_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .req       (req),
        .req_wr    (w_is_wr),
        .req_addr  (w_addr),
        .req_wdata (w_data),
        .fin       (fin),
        .rd_data   (rd_data),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_rdata (bus_rdata),
        .bus_ack   (bus_ack)
    );

    pls_poll_timer #(.CNT_W(CNT_W)) u_timer (
        .clk          (clk),
        .rst_n        (rst_n),
        .clr          (tmr_clr),
        .tick         (tmr_tick),
        .limit        (limit_q),
        .last_allowed (last_allowed)
    );

    assign busy    = s_q.busy;
    assign done    = s_q.done;
    assign err     = s_q.err;
    assign tmo     = s_q.tmo;
    assign arg_err = s_q.arg_err;

endmodule

// File: rtl/pls_checker.sv
module pls_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        start,
    input logic [15:0] bus_addr,
    input logic [15:0] bus_wdata,
    input logic        bus_wr,
    input logic        bus_rd,
    input logic        bus_ack,
    input logic        busy,
    input logic        done
);

    assert_one_strobe_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && bus_rd));

    assert_hold_until_ack_R11: assert property (@(posedge clk) disable iff (!rst_n)
        ((bus_wr || bus_rd) && !bus_ack) |=>
            (bus_wr == $past(bus_wr)) && (bus_rd == $past(bus_rd))
            && $stable(bus_addr) && $stable(bus_wdata));

    assert_done_single_R13: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_quiet_idle_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !(bus_wr || bus_rd));

    assert_busy_needs_start_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start));

    assert_done_ends_busy_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    assert_cmd_word_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 16'hF220) |->
            (bus_wdata == 16'h0000 || bus_wdata == 16'h0013));

    assert_clear_word_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == 16'hF241) |-> (bus_wdata == 16'h0000));

endmodule

bind page_load_seq pls_checker u_pls_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_ack   (bus_ack),
    .busy      (busy),
    .done      (done)
);

// File: tb/page_load_seq_test.sv
`timescale 1ns/1ps
module page_load_seq_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  blk_addr = '0;
    logic [5:0]  page_addr = '0;
    logic [1:0]  sect_addr = '0;
    logic [1:0]  buf_sect = '0;
    logic [2:0]  buf_count = 3'd1;
    logic        die_sel = 1'b0;
    logic        buf_sel = 1'b0;
    logic        cmd_alt = 1'b0;
    logic        auto_clear = 1'b0;
    logic [15:0] poll_limit = '0;
    logic [15:0] bus_addr, bus_wdata, bus_rdata;
    logic        bus_wr, bus_rd, bus_ack;
    logic        busy, done, err, tmo, arg_err;

    always #4 clk = ~clk;

    page_load_seq uut (
        .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
        .page_addr(page_addr), .sect_addr(sect_addr), .buf_sect(buf_sect),
        .buf_count(buf_count), .die_sel(die_sel), .buf_sel(buf_sel),
        .cmd_alt(cmd_alt), .auto_clear(auto_clear), .poll_limit(poll_limit),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .busy(busy), .done(done), .err(err), .tmo(tmo), .arg_err(arg_err)
    );

    int n_chk = 0;
    int n_fail = 0;

    task automatic check(input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // device model
    logic [15:0] log_addr [64];
    logic [15:0] log_data [64];
    logic        log_wr   [64];
    int log_n = 0, poll_k = 0, dly = 0, both_cnt = 0, done_cnt = 0;
    int ack_delay = 0, pre_high = 0, low_n = 1;
    logic stat_err = 1'b0;

    function automatic logic [15:0] poll_word(input int k);
        if (k < pre_high)         return 16'h8000;
        if (k < pre_high + low_n) return 16'h7FFF;
        return 16'h8000;
    endfunction

    always @(posedge clk) begin
        if (done) done_cnt++;
        if (!rst_n) begin
            bus_ack   <= 1'b0;
            bus_rdata <= '0;
            dly        = 0;
        end else begin
            bus_ack <= 1'b0;
            if (bus_wr && bus_rd) both_cnt++;
            if ((bus_wr || bus_rd) && !bus_ack) begin
                if (dly >= ack_delay) begin
                    dly = 0;
                    bus_ack <= 1'b1;
                    if (log_n < 64) begin
                        log_addr[log_n] = bus_addr;
                        log_data[log_n] = bus_wdata;
                        log_wr[log_n]   = bus_wr;
                    end
                    log_n++;
                    if (bus_rd) begin
                        if (bus_addr == 16'hF241) begin
                            bus_rdata <= poll_word(poll_k);
                            poll_k++;
                        end else if (bus_addr == 16'hF240)
                            bus_rdata <= stat_err ? 16'h0400 : 16'hFBFF;
                        else
                            bus_rdata <= 16'hDEAD;
                    end
                end else dly++;
            end
        end
    end

    // watchdog
    int cyc_all = 0;
    always @(posedge clk) begin
        cyc_all++;
        if (cyc_all > 150000) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected <= 150000 cycles", cyc_all);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    task automatic clear_log();
        log_n = 0;
        poll_k = 0;
    endtask

    task automatic entry(input int i, input logic wr, input logic [15:0] a,
                         input logic [15:0] d, input string req);
        check(req, $sformatf("entry %0d dir", i), log_wr[i], wr);
        check(req, $sformatf("entry %0d addr", i), log_addr[i], a);
        if (wr) check(req, $sformatf("entry %0d data", i), log_data[i], d);
    endtask

    // pulse start and wait for done; returns cycles waited
    task automatic go(output int cyc);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        cyc = 1;
        while (!done && cyc < 3000) begin
            @(negedge clk);
            cyc++;
        end
        check("R13", "done seen", done, 1);
        @(negedge clk);
        check("R13", "done single cycle", done, 0);
    endtask

    task automatic t_reset();
        check("R10", "reset busy", busy, 0);
        check("R13", "reset done", done, 0);
        check("R13", "reset flags", {err, tmo, arg_err}, 0);
        check("R11", "reset strobes", {bus_wr, bus_rd}, 0);
    endtask

    task automatic t_basic();
        int c;
        clear_log();
        blk_addr = 10'h2A5; page_addr = 6'h15; sect_addr = 2'd2;
        buf_sect = 2'd1; buf_count = 3'd3; die_sel = 1'b1; buf_sel = 1'b0;
        cmd_alt = 1'b0; auto_clear = 1'b0; poll_limit = 16'd0;
        ack_delay = 0; pre_high = 0; low_n = 3; stat_err = 1'b0;
        go(c);
        check("R10", "busy after done", busy, 0);
        check("R8", "basic count", log_n, 11);
        entry(0, 1, 16'hF100, 16'h82A5, "R1");
        entry(1, 1, 16'hF107, 16'h0056, "R2");
        entry(2, 1, 16'hF200, 16'h0102, "R3");
        entry(3, 1, 16'hF101, 16'h0000, "R4");
        entry(4, 1, 16'hF220, 16'h0000, "R5");
        for (int i = 5; i < 9; i++) entry(i, 0, 16'hF241, 0, "R6");
        entry(9, 0, 16'hF240, 0, "R7");
        entry(10, 1, 16'hF241, 16'h0000, "R8");
        check("R7", "err clear status", err, 0);
        check("R12", "no tmo", tmo, 0);
        check("R11", "strobes exclusive", both_cnt, 0);
    endtask

    task automatic t_alt();
        int c;
        clear_log();
        blk_addr = 10'h15A; page_addr = 6'h2A; sect_addr = 2'd1;
        buf_sect = 2'd0; buf_count = 3'd4; die_sel = 1'b0; buf_sel = 1'b1;
        cmd_alt = 1'b1; auto_clear = 1'b1; poll_limit = 16'd0;
        ack_delay = 2; pre_high = 0; low_n = 1; stat_err = 1'b1;
        go(c);
        check("R8", "auto count", log_n, 8);
        entry(0, 1, 16'hF100, 16'h015A, "R1");
        entry(1, 1, 16'hF107, 16'h00A9, "R2");
        entry(2, 1, 16'hF200, 16'h0003, "R3");
        entry(3, 1, 16'hF101, 16'h8000, "R4");
        entry(4, 1, 16'hF220, 16'h0013, "R5");
        entry(7, 0, 16'hF240, 0, "R7");
        check("R7", "err set", err, 1);
        check("R11", "strobes exclusive delayed", both_cnt, 0);
    endtask

    task automatic t_stale_high();
        int c;
        clear_log();
        buf_sect = 2'd3; buf_count = 3'd1; cmd_alt = 1'b0; auto_clear = 1'b0;
        ack_delay = 1; pre_high = 2; low_n = 1; stat_err = 1'b0;
        go(c);
        check("R6", "stale high polls", poll_k, 4);
        check("R6", "stale count", log_n, 11);
        entry(9, 0, 16'hF240, 0, "R6");
        check("R13", "err cleared by start", err, 0);
    endtask

    task automatic t_timeout();
        int c;
        clear_log();
        ack_delay = 0; pre_high = 0; low_n = 1000; poll_limit = 16'd5;
        go(c);
        check("R12", "tmo set", tmo, 1);
        check("R12", "polls before abort", log_n, 10);
        check("R12", "last is poll", log_addr[9], 16'hF241);
        check("R12", "no err", err, 0);
        repeat (5) @(negedge clk);
        check("R12", "silent after abort", log_n, 10);
    endtask

    task automatic t_limit_edge();
        int c;
        clear_log();
        low_n = 3; poll_limit = 16'd4;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        check("R13", "tmo cleared by start", tmo, 0);
        check("R10", "busy after start", busy, 1);
        c = 0;
        while (!done && c < 3000) begin @(negedge clk); c++; end
        check("R12", "completion wins at limit", tmo, 0);
        check("R12", "edge count", log_n, 11);
        @(negedge clk);
    endtask

    task automatic t_no_limit();
        int c;
        clear_log();
        low_n = 40; poll_limit = 16'd0;
        go(c);
        check("R12", "limit zero no tmo", tmo, 0);
        check("R12", "limit zero polls", poll_k, 41);
        check("R12", "limit zero count", log_n, 48);
    endtask

    task automatic bad_one(input logic [1:0] s, input logic [2:0] n);
        int c;
        clear_log();
        buf_sect = s; buf_count = n;
        go(c);
        check("R9", $sformatf("reject latency s%0d n%0d", s, n), c, 1);
        check("R9", "arg_err", arg_err, 1);
        check("R9", "no traffic", log_n, 0);
        check("R10", "busy stays low", busy, 0);
    endtask

    task automatic t_bad_args();
        bad_one(2'd0, 3'd0);
        bad_one(2'd2, 3'd3);
        bad_one(2'd0, 3'd5);
        buf_sect = 2'd1; buf_count = 3'd3;
    endtask

    task automatic t_busy_ignore();
        int c, d0;
        clear_log();
        blk_addr = 10'h111; buf_sect = 2'd0; buf_count = 3'd2;
        low_n = 10; poll_limit = 16'd0; d0 = done_cnt;
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (8) @(negedge clk);
        blk_addr = 10'h3FF; buf_count = 3'd0;
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        c = 0;
        while (!done && c < 3000) begin @(negedge clk); c++; end
        @(negedge clk);
        repeat (4) @(negedge clk);
        check("R10", "ignored start arg_err", arg_err, 0);
        check("R10", "single done", done_cnt - d0, 1);
        check("R10", "original block", log_data[0], 16'h0111);
        check("R10", "count unchanged", log_n, 18);
        buf_count = 3'd1;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_basic();
        t_alt();
        t_stale_high();
        t_timeout();
        t_limit_edge();
        t_no_limit();
        t_bad_args();
        t_busy_ignore();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule